// File: doc/BRIEF.md
# Command Chain Sequencer

This block is the control engine of an attached arithmetic coprocessor. It sits in an idle wait loop until the host raises a go condition together with a pointer into shared memory. It then walks a linked list of four-word command records held in that memory. For each record it reads the words through a single-ported synchronous memory interface and launches the command on an external execution unit. When the unit answers, the block stores the result at the destination the record names.

Each finished command raises a level interrupt to the host. An execution fault raises the interrupt along with an error flag and abandons the rest of the list. When the link word of a record is zero, the sequencer returns to its wait loop and is ready for the next host go. The arithmetic itself lives outside this block; only the handshake to the execution unit is modelled here.

Top module: `cmd_chain_ctrl`

## Requirements
- R1: After reset `irq`, `errFlag`, `memRdReq`, `memWrReq` and `execStart` are 0 and `chainIdle` is 1.
- R2: While idle the block issues no memory request and no `execStart`. It leaves idle only on `hostGo`, and it latches `hostPtr` as the address of the first record.
- R3: A record at word address P is read in the order P+0 (opcode), P+1 (source address, low `AW` bits), P+2 (destination address, low `AW` bits), P+3 (link address, low `AW` bits).
- R4: Each read holds `memRdReq` and `memAddr` steady until `memRdValid` is seen. Data is captured only in the cycle where `memRdValid` is 1.
- R5: After the four reads, `execStart` pulses for exactly one cycle. During that pulse `execOpcode` and `execSrc` carry the record's opcode and source. The block then waits for `execDone` or `execError`.
- R6: On `execDone` without `execError`, the block issues exactly one single-cycle `memWrReq`. The write goes to the record's destination, with `memWrData` equal to the `execResult` value presented with `execDone`.
- R7: A completed store sets `irq` one cycle later. `irq` stays 1 until a cycle with `irqClr`. If a set and `irqClr` fall in the same cycle, the set wins.
- R8: After the store, a non-zero link starts the reads of the record at that address. A zero link returns the block to idle (`chainIdle` = 1).
- R9: `execError` (checked before `execDone`, so both together count as an error) sets `irq` and `errFlag`. The block performs no store and returns to idle without fetching further records.
- R10: `hostGo` while a chain is running is ignored. The running chain is not redirected, and no new chain starts once it ends.
- R11: `irqClr` clears `errFlag` together with `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostGo | input | 1 | Host go condition, sampled while idle |
| hostPtr | input | AW | Address of the first record, latched with hostGo |
| irqClr | input | 1 | Host clear strobe for irq and errFlag |
| irq | output | 1 | Level interrupt to the host |
| errFlag | output | 1 | Error status held alongside irq |
| chainIdle | output | 1 | 1 while in the wait loop |
| memRdReq | output | 1 | Read request, held until memRdValid |
| memWrReq | output | 1 | Single-cycle write strobe |
| memAddr | output | AW | Word address for read or write |
| memWrData | output | DW | Write data (command result) |
| memRdData | input | DW | Read data, qualified by memRdValid |
| memRdValid | input | 1 | Read data valid strobe |
| execStart | output | 1 | One-cycle launch of the execution unit |
| execOpcode | output | DW | Opcode of the current record |
| execSrc | output | AW | Source block address of the current record |
| execDone | input | 1 | Execution unit completion strobe |
| execError | input | 1 | Execution unit fault strobe |
| execResult | input | DW | Result presented with execDone |

## Verification
The host clear strobe and the interrupt set from a completed store can land on the same clock edge. In that case `irq` must stay set so that no completion is lost. The bench provokes this by raising `irqClr` in exactly the cycle where it sees `memWrReq`, and it expects `irq` to read 1 in the following cycle. The execution unit's completion and fault strobes can also arrive together. The bench does this on every faulting command and judges it by the absence of any write for that record, the error flag and the number of records read. Randomized read latency and execution delays move the remaining events against each other across many chains.

// File: rtl/cmd_chain_pkg.sv
package cmd_chain_pkg;

  typedef enum logic [3:0] {
    ST_WAIT, ST_RD_OP, ST_RD_SRC, ST_RD_DST, ST_RD_NXT,
    ST_LAUNCH, ST_BUSY, ST_STORE, ST_LINK
  } ctrlState_e;

  // word offset inside a record; the order is the read order
  typedef enum logic [1:0] {
    SEL_OP  = 2'd0,
    SEL_SRC = 2'd1,
    SEL_DST = 2'd2,
    SEL_NXT = 2'd3
  } wordSel_e;

  typedef struct packed {
    logic     loadHost;
    logic     loadLink;
    logic     capWord;
    wordSel_e sel;
    logic     capResult;
    logic     addrDst;
    logic     setIrq;
    logic     setErr;
  } ctrlStrobe_t;

endpackage

// File: rtl/cmd_chain_dp.sv
module cmd_chain_dp
  import cmd_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobe_t   strobe,
  input  logic [AW-1:0] hostPtr,
  input  logic          irqClr,
  input  logic [DW-1:0] memRdData,
  input  logic [DW-1:0] execResult,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  output logic [DW-1:0] execOpcode,
  output logic [AW-1:0] execSrc,
  output logic          linkZero,
  output logic          irq,
  output logic          errFlag
);

  localparam int SelPad = AW - 2;

  logic [AW-1:0] ptrQ, srcQ, dstQ, nxtQ;
  logic [DW-1:0] opQ, resQ;
  logic          irqQ, errQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptrQ <= '0;
      srcQ <= '0;
      dstQ <= '0;
      nxtQ <= '0;
      opQ  <= '0;
      resQ <= '0;
    end else begin
      if (strobe.loadHost)      ptrQ <= hostPtr;
      else if (strobe.loadLink) ptrQ <= nxtQ;
      if (strobe.capWord) begin
        case (strobe.sel)
          SEL_OP:  opQ  <= memRdData;
          SEL_SRC: srcQ <= memRdData[AW-1:0];
          SEL_DST: dstQ <= memRdData[AW-1:0];
          default: nxtQ <= memRdData[AW-1:0];
        endcase
      end
      if (strobe.capResult) resQ <= execResult;
    end
  end

  // interrupt and error status: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      if (strobe.setIrq)  irqQ <= 1'b1;
      else if (irqClr)    irqQ <= 1'b0;
      if (strobe.setErr)  errQ <= 1'b1;
      else if (irqClr)    errQ <= 1'b0;
    end
  end

  assign memAddr    = strobe.addrDst ? dstQ : ptrQ + {{SelPad{1'b0}}, strobe.sel};
  assign memWrData  = resQ;
  assign execOpcode = opQ;
  assign execSrc    = srcQ;
  assign linkZero   = (nxtQ == '0);
  assign irq        = irqQ;
  assign errFlag    = errQ;

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irqQ && !irqClr |=> irqQ);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setIrq |=> irqQ);

  assert_err_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    errQ |-> irqQ);

endmodule

// File: rtl/cmd_chain_fsm.sv
module cmd_chain_fsm
  import cmd_chain_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hostGo,
  input  logic        memRdValid,
  input  logic        execDone,
  input  logic        execError,
  input  logic        linkZero,
  output ctrlStrobe_t strobe,
  output logic        memRdReq,
  output logic        memWrReq,
  output logic        execStart,
  output logic        chainIdle
);

  ctrlState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_WAIT;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    strobe    = '0;
    memRdReq  = 1'b0;
    memWrReq  = 1'b0;
    execStart = 1'b0;
    case (stateQ)
      ST_WAIT: begin
        if (hostGo) begin
          strobe.loadHost = 1'b1;
          stateD = ST_RD_OP;
        end
      end
      ST_RD_OP: begin
        memRdReq = 1'b1;
        strobe.sel = SEL_OP;
        if (memRdValid) begin
          strobe.capWord = 1'b1;
          stateD = ST_RD_SRC;
        end
      end
      ST_RD_SRC: begin
        memRdReq = 1'b1;
        strobe.sel = SEL_SRC;
        if (memRdValid) begin
          strobe.capWord = 1'b1;
          stateD = ST_RD_DST;
        end
      end
      ST_RD_DST: begin
        memRdReq = 1'b1;
        strobe.sel = SEL_DST;
        if (memRdValid) begin
          strobe.capWord = 1'b1;
          stateD = ST_RD_NXT;
        end
      end
      ST_RD_NXT: begin
        memRdReq = 1'b1;
        strobe.sel = SEL_NXT;
        if (memRdValid) begin
          strobe.capWord = 1'b1;
          stateD = ST_LAUNCH;
        end
      end
      ST_LAUNCH: begin
        execStart = 1'b1;
        stateD = ST_BUSY;
      end
      ST_BUSY: begin
        if (execError) begin
          strobe.setIrq = 1'b1;
          strobe.setErr = 1'b1;
          stateD = ST_WAIT;
        end else if (execDone) begin
          strobe.capResult = 1'b1;
          stateD = ST_STORE;
        end
      end
      ST_STORE: begin
        memWrReq = 1'b1;
        strobe.addrDst = 1'b1;
        strobe.setIrq = 1'b1;
        stateD = ST_LINK;
      end
      ST_LINK: begin
        if (linkZero) begin
          stateD = ST_WAIT;
        end else begin
          strobe.loadLink = 1'b1;
          stateD = ST_RD_OP;
        end
      end
      default: stateD = ST_WAIT;
    endcase
  end

  assign chainIdle = (stateQ == ST_WAIT);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chainIdle |-> !(memRdReq || memWrReq || execStart));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    execStart |=> !execStart);

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memWrReq |=> !memWrReq);

  assert_port_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(memRdReq && memWrReq));

  assert_read_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    memRdReq && !memRdValid |=> memRdReq && $stable(strobe.sel));

endmodule

// File: rtl/cmd_chain_ctrl.sv
module cmd_chain_ctrl
  import cmd_chain_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hostGo,
  input  logic [AW-1:0] hostPtr,
  input  logic          irqClr,
  output logic          irq,
  output logic          errFlag,
  output logic          chainIdle,
  output logic          memRdReq,
  output logic          memWrReq,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWrData,
  input  logic [DW-1:0] memRdData,
  input  logic          memRdValid,
  output logic          execStart,
  output logic [DW-1:0] execOpcode,
  output logic [AW-1:0] execSrc,
  input  logic          execDone,
  input  logic          execError,
  input  logic [DW-1:0] execResult
);

  ctrlStrobe_t strobe;
  logic        linkZero;

  cmd_chain_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostGo     (hostGo),
    .memRdValid (memRdValid),
    .execDone   (execDone),
    .execError  (execError),
    .linkZero   (linkZero),
    .strobe     (strobe),
    .memRdReq   (memRdReq),
    .memWrReq   (memWrReq),
    .execStart  (execStart),
    .chainIdle  (chainIdle)
  );

  cmd_chain_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .hostPtr    (hostPtr),
    .irqClr     (irqClr),
    .memRdData  (memRdData),
    .execResult (execResult),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .execOpcode (execOpcode),
    .execSrc    (execSrc),
    .linkZero   (linkZero),
    .irq        (irq),
    .errFlag    (errFlag)
  );

endmodule

// File: tb/cmd_chain_ctrl_tb.sv
`timescale 1ns/1ps
module cmd_chain_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hostGo = 1'b0;
  logic [AW-1:0] hostPtr = '0;
  logic irqClr = 1'b0;
  logic irq, errFlag, chainIdle, memRdReq, memWrReq, execStart;
  logic [AW-1:0] memAddr, execSrc;
  logic [DW-1:0] memWrData, execOpcode;
  logic [DW-1:0] memRdData = '0;
  logic memRdValid = 1'b0;
  logic execDone = 1'b0;
  logic execError = 1'b0;
  logic [DW-1:0] execResult = '0;

  always #2.5 clk = ~clk;

  cmd_chain_ctrl #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hostGo(hostGo), .hostPtr(hostPtr), .irqClr(irqClr),
    .irq(irq), .errFlag(errFlag), .chainIdle(chainIdle),
    .memRdReq(memRdReq), .memWrReq(memWrReq), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memRdValid(memRdValid),
    .execStart(execStart), .execOpcode(execOpcode), .execSrc(execSrc),
    .execDone(execDone), .execError(execError), .execResult(execResult)
  );

  logic [31:0] mem [0:255];
  int expRdAddr [0:63];
  int expWrAddr [0:15];
  logic [31:0] expWrData [0:15];
  logic [31:0] expOp [0:15];
  int nRdExp, nWrExp, rdIdx, wrIdx, opIdx, rdTotal;
  int nChecks = 0;
  int nFails = 0;
  bit monOn = 0;
  bit autoClear = 1;
  bit collideOnce = 0;
  bit collideCheck = 0;
  bit clrCheck = 0;
  bit prevStart = 0;
  int rdWait = 0;
  int execCnt = 0;
  logic [31:0] exOp, exSrc;

  function automatic logic [31:0] expResult(logic [31:0] op, logic [31:0] src);
    return op * 32'd3 + src;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory, execution unit and interrupt handler models
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (collideCheck) begin
          check(irq == 1'b1, "R7", "irq after same-cycle set and clear", {31'd0, irq}, 32'd1);
          collideCheck = 0;
          irqClr = 1'b0;
        end else if (clrCheck) begin
          check(irq == 1'b0 && errFlag == 1'b0, "R11", "irq/errFlag after clear",
                {30'd0, irq, errFlag}, 32'd0);
          clrCheck = 0;
          irqClr = 1'b0;
        end else if (autoClear && irq) begin
          irqClr = 1'b1;
          clrCheck = 1;
        end
        // reads
        if (memRdValid) begin
          memRdValid = 1'b0;
        end else if (memRdReq) begin
          if (rdWait == 0) begin
            check(rdIdx < nRdExp && int'(memAddr) == expRdAddr[rdIdx % 64], "R3", "read address",
                  {16'd0, memAddr}, expRdAddr[rdIdx % 64]);
            memRdData = mem[memAddr[7:0]];
            memRdValid = 1'b1;
            rdIdx++;
            rdTotal++;
            rdWait = $urandom % 3;
          end else begin
            check(rdIdx < nRdExp && int'(memAddr) == expRdAddr[rdIdx % 64], "R4", "address held while waiting",
                  {16'd0, memAddr}, expRdAddr[rdIdx % 64]);
            rdWait--;
          end
        end
        // writes
        if (memWrReq) begin
          check(wrIdx < nWrExp && int'(memAddr) == expWrAddr[wrIdx % 16], "R6", "write address",
                {16'd0, memAddr}, expWrAddr[wrIdx % 16]);
          check(wrIdx < nWrExp && memWrData == expWrData[wrIdx % 16], "R6", "write data",
                memWrData, expWrData[wrIdx % 16]);
          mem[memAddr[7:0]] = memWrData;
          wrIdx++;
          if (collideOnce) begin
            irqClr = 1'b1;
            collideCheck = 1;
            collideOnce = 0;
          end
        end
        // execution unit
        if (execDone) begin
          execDone = 1'b0;
          execError = 1'b0;
        end
        if (execStart) begin
          check(!prevStart, "R5", "execStart width", 32'd2, 32'd1);
          check(execOpcode == expOp[opIdx % 16], "R5", "opcode at launch", execOpcode, expOp[opIdx % 16]);
          opIdx++;
          exOp = execOpcode;
          exSrc = {16'd0, execSrc};
          execCnt = 1 + ($urandom % 3);
        end else if (execCnt > 0) begin
          execCnt--;
          if (execCnt == 0) begin
            execDone = 1'b1;
            execError = exOp[31];
            execResult = expResult(exOp, exSrc);
          end
        end
        prevStart = execStart;
      end
    end
  end

  // lay out a chain of n records; errAt < 0 means no faulting record
  task automatic buildChain(int n, int errAt, int slot);
    int base [0:15];
    int last;
    for (int i = 0; i < n; i++) base[i] = 16 + 8 * ((slot + i * 5) % 28);
    last = (errAt >= 0) ? errAt : n - 1;
    nRdExp = 0; nWrExp = 0; rdIdx = 0; wrIdx = 0; opIdx = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] op, src;
      op  = $urandom & 32'h7fff_ffff;
      if (i == errAt) op[31] = 1'b1;
      src = {16'd0, 16'($urandom)};
      mem[base[i]]     = op;
      mem[base[i] + 1] = {16'hbeef, src[15:0]};
      mem[base[i] + 2] = {16'ha5a5, 16'(240 + i)};
      mem[base[i] + 3] = (i == n - 1) ? 32'd0 : {16'hc3c3, 16'(base[i + 1])};
      expOp[i] = op;
      if (i <= last) begin
        for (int k = 0; k < 4; k++) begin
          expRdAddr[nRdExp] = base[i] + k;
          nRdExp++;
        end
      end
      if (i < last || (i == last && errAt < 0)) begin
        expWrAddr[nWrExp] = 240 + i;
        expWrData[nWrExp] = expResult(op, src);
        nWrExp++;
      end
    end
    hostPtr = 16'(base[0]);
  endtask

  task automatic runChain(bit spam, string req);
    int cyc;
    @(negedge clk);
    hostGo = 1'b1;
    @(negedge clk);
    hostGo = 1'b0;
    check(chainIdle == 1'b0, "R2", "leaves idle on hostGo", {31'd0, chainIdle}, 32'd0);
    cyc = 0;
    while (!chainIdle && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (spam && cyc == 10) begin hostGo = 1'b1; hostPtr = 16'd200; end
      if (spam && cyc == 11) hostGo = 1'b0;
    end
    check(chainIdle == 1'b1, req, "chain returned to idle", {31'd0, chainIdle}, 32'd1);
    check(rdIdx == nRdExp, req, "number of record reads", rdIdx, nRdExp);
    check(wrIdx == nWrExp, req, "number of stores", wrIdx, nWrExp);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irq == 0 && errFlag == 0, "R1", "irq/errFlag in reset", {30'd0, irq, errFlag}, 32'd0);
    check(chainIdle == 1, "R1", "idle in reset", {31'd0, chainIdle}, 32'd1);
    check(!memRdReq && !memWrReq && !execStart, "R1", "no requests in reset",
          {29'd0, memRdReq, memWrReq, execStart}, 32'd0);
    rst_n = 1'b1;
    monOn = 1;
    rdTotal = 0; nRdExp = 0; nWrExp = 0;
    // R2: stays in wait loop without hostGo
    repeat (20) @(negedge clk);
    check(chainIdle == 1 && rdTotal == 0, "R2", "idle without hostGo", rdTotal, 32'd0);

    // R8 R10 R7: three records, hostGo spam, set/clear collision on first store
    collideOnce = 1;
    buildChain(3, -1, 0);
    runChain(1, "R10");
    check(chainIdle == 1 && !memRdReq, "R10", "no late chain after ignored hostGo",
          {30'd0, chainIdle, memRdReq}, 32'd2);

    // R7: normal completion holds irq without clear
    autoClear = 0;
    buildChain(1, -1, 7);
    runChain(0, "R8");
    repeat (6) @(negedge clk);
    check(irq == 1 && errFlag == 0, "R7", "irq held, no error", {30'd0, irq, errFlag}, 32'd2);
    autoClear = 1;
    repeat (4) @(negedge clk);
    check(irq == 0, "R7", "irq cleared by irqClr", {31'd0, irq}, 32'd0);

    // R9: fault on second record aborts chain
    autoClear = 0;
    buildChain(4, 1, 3);
    runChain(0, "R9");
    repeat (6) @(negedge clk);
    check(irq == 1 && errFlag == 1, "R9", "irq and errFlag after fault", {30'd0, irq, errFlag}, 32'd3);
    autoClear = 1;
    repeat (4) @(negedge clk);
    check(irq == 0 && errFlag == 0, "R11", "errFlag cleared with irq", {30'd0, irq, errFlag}, 32'd0);

    // R3 R4 R6 R8: random chains
    for (int t = 0; t < 20; t++) begin
      int n;
      n = 1 + ($urandom % 4);
      buildChain(n, ($urandom % 5 == 0) ? int'($urandom % n) : -1, int'($urandom % 28));
      runChain(0, "R8");
      repeat (4) @(negedge clk);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule